// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block gathers a set of memory blocks that are to be erased and then runs one erase over all of them. The first block select opens a selection window measured in microsecond ticks. Each later select adds one more block and starts the window again. When the window runs out with no new select, the erase starts. From that point selects are ignored, and any block whose protection bit is set is removed from the set. A progress counter stands in for the erase itself. It needs a fixed number of ticks for each unprotected block. When every chosen block is protected, it runs for a shorter fixed time and changes nothing.

A suspend request has two behaviours. If it arrives while the window is still open, the block suspends on the next clock edge. The later resume then starts the erase at once and closes the window. If it arrives while the erase is running, the block suspends only after a fixed tick latency, and erase progress continues during that latency. An erase can be suspended and resumed any number of times. An abort request ends the operation after its own tick latency, and the contents of the chosen blocks are then undefined. When several requests arrive in one cycle, abort is taken first, then suspend, then resume, then select.

Top module: `erase_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, started and suspended are low and erase_mask is all zeros.
- R2: When the block is idle or in the window and no abort, suspend or resume is requested, a select sets bit sel_idx of erase_mask on the next clock edge (bit i of the mask stands for block i) and raises busy.
- R3: The erase starts on the edge of the WIN_US-th tick that follows the last accepted select. Every accepted select restarts this count, and cycles with us_tick low do not advance it. started rises on the start edge.
- R4: After the start, selects are ignored. On the start edge erase_mask loses the bits of protected blocks and then stays fixed until busy falls.
- R5: An erase of N unprotected blocks ends after N×BLK_US running ticks. Ticks spent suspended do not count. On the end edge, busy and started fall and erase_mask clears.
- R6: If every selected block is protected, erase_mask is empty from the start edge and busy stays high for EMPTY_US ticks.
- R7: A suspend while the erase runs raises suspended on the edge of the SUSP_US-th tick after the request, and progress continues until then. If the erase ends first, the block goes idle and suspended never rises.
- R8: A suspend inside the window raises suspended on the next edge and stops the window. Selects are ignored while suspended. A resume then starts the erase on its edge, so started rises and suspended falls.
- R9: A resume after a running-phase suspend continues from the progress already made, and suspend and resume may repeat any number of times.
- R10: An abort while busy clears suspended on the next edge. busy stays high for ABORT_US ticks, after which busy and started fall and erase_mask clears.
- R11: query_erasing is high exactly when busy is high and bit query_idx of erase_mask is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| sel_valid | input | 1 | Select request for the block in sel_idx |
| sel_idx | input | IDX_W | Index of the block to add |
| susp_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| abort_req | input | 1 | Abort request |
| blk_prot | input | NUM_BLK | Protection bit for each block |
| query_idx | input | IDX_W | Block index for the erasing query |
| erase_mask | output | NUM_BLK | Current set of blocks |
| busy | output | 1 | Operation in progress |
| started | output | 1 | Selection closed and erase launched |
| suspended | output | 1 | Erase held in suspend |
| query_erasing | output | 1 | Queried block is being erased |

## Verification
All outputs come from registers. A request driven before an edge shows on the outputs right after that edge. Anything that depends on the tick counters changes on the edge of the last counted tick. Those edges are the window length after the last select, the suspend or abort latency after entry, and the erase length counted only over running ticks. The bench drives each request for exactly one edge and then waits a number of edges worked out from those counts. It samples at the falling edge one step before and one step after each expected change, which catches results that come one edge early or one edge late.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_RUN   = 3'd2,
    ST_SPEND = 3'd3,
    ST_SUSP  = 3'd4,
    ST_ABORT = 3'd5
  } ebs_state_t;
endpackage

// File: rtl/ebs_tick_ctr.sv
// Counts us ticks while enabled; flags the tick that reaches the limit.
module ebs_tick_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr || done) cnt <= '0;
    else if (run && tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ebs_block_set.sv
// One register bit per block: set by select, pruned of protected blocks at start.
module ebs_block_set #(
  parameter int NUM_BLK = 8,
  parameter int IDX_W   = 3,
  parameter int NB_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add_en,
  input  logic [IDX_W-1:0]   add_idx,
  input  logic               prune_en,
  input  logic [NUM_BLK-1:0] prot,
  input  logic               clear_en,
  input  logic [IDX_W-1:0]   query_idx,
  output logic [NUM_BLK-1:0] mask,
  output logic [NB_W-1:0]    live_cnt,
  output logic               q_hit
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLK; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || clear_en)                     mask[gi] <= 1'b0;
        else if (prune_en && prot[gi])           mask[gi] <= 1'b0;
        else if (add_en && add_idx == IDX_W'(gi)) mask[gi] <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    live_cnt = '0;
    for (int i = 0; i < NUM_BLK; i++)
      live_cnt = live_cnt + NB_W'(mask[i] & ~prot[i]);
  end

  assign q_hit = mask[query_idx];
endmodule

// File: rtl/erase_sched.sv
module erase_sched #(
  parameter int NUM_BLK  = 8,
  parameter int WIN_US   = 50,
  parameter int SUSP_US  = 15,
  parameter int ABORT_US = 10,
  parameter int BLK_US   = 20,
  parameter int EMPTY_US = 100,
  localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               us_tick,
  input  logic               sel_valid,
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic               susp_req,
  input  logic               resume_req,
  input  logic               abort_req,
  input  logic [NUM_BLK-1:0] blk_prot,
  input  logic [IDX_W-1:0]   query_idx,
  output logic [NUM_BLK-1:0] erase_mask,
  output logic               busy,
  output logic               started,
  output logic               suspended,
  output logic               query_erasing
);
  import ebs_pkg::*;

  localparam int NB_W  = $clog2(NUM_BLK + 1);
  localparam int SPAN  = NUM_BLK * BLK_US + EMPTY_US + WIN_US + SUSP_US + ABORT_US + 2;
  localparam int CNT_W = $clog2(SPAN);

  ebs_state_t         state, nxt;
  logic               started_q;
  logic [CNT_W-1:0]   target_q, target_d;
  logic [NB_W-1:0]    live_cnt;
  logic               q_hit;
  logic               sel_acc, start_evt, clear_set;
  logic               win_done, ph_done, prog_done;
  logic               win_clr, ph_clr, ph_run, prog_clr, prog_run;
  logic [CNT_W-1:0]   ph_limit;

  // Next-state selection; abort > suspend > resume > select.
  always_comb begin
    nxt       = state;
    sel_acc   = 1'b0;
    start_evt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sel_valid) begin
          nxt     = ST_WIN;
          sel_acc = 1'b1;
        end
      end
      ST_WIN: begin
        if (abort_req)      nxt = ST_ABORT;
        else if (susp_req)  nxt = ST_SUSP;
        else if (sel_valid) sel_acc = 1'b1;
        else if (win_done) begin
          nxt       = ST_RUN;
          start_evt = 1'b1;
        end
      end
      ST_RUN: begin
        if (abort_req)      nxt = ST_ABORT;
        else if (susp_req)  nxt = ST_SPEND;
        else if (prog_done) nxt = ST_IDLE;
      end
      ST_SPEND: begin
        if (abort_req)      nxt = ST_ABORT;
        else if (prog_done) nxt = ST_IDLE;
        else if (ph_done)   nxt = ST_SUSP;
      end
      ST_SUSP: begin
        if (abort_req) nxt = ST_ABORT;
        else if (resume_req) begin
          nxt       = ST_RUN;
          start_evt = !started_q;
        end
      end
      ST_ABORT: begin
        if (ph_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign clear_set = (state != ST_IDLE) && (nxt == ST_IDLE);

  always_comb begin
    if (live_cnt == '0) target_d = CNT_W'(EMPTY_US);
    else                target_d = CNT_W'(live_cnt) * CNT_W'(BLK_US);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      started_q <= 1'b0;
      target_q  <= '0;
    end else begin
      state <= nxt;
      if (start_evt)      started_q <= 1'b1;
      else if (clear_set) started_q <= 1'b0;
      if (start_evt) target_q <= target_d;
    end
  end

  // Selection window timer.
  assign win_clr = sel_acc || (state != ST_WIN);

  ebs_tick_ctr #(.W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .clr(win_clr), .run(state == ST_WIN),
    .tick(us_tick), .limit(CNT_W'(WIN_US)), .done(win_done)
  );

  // Latency timer shared by suspend-pending and abort.
  assign ph_run   = (state == ST_SPEND) || (state == ST_ABORT);
  assign ph_clr   = (nxt != state);
  assign ph_limit = (state == ST_ABORT) ? CNT_W'(ABORT_US) : CNT_W'(SUSP_US);

  ebs_tick_ctr #(.W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .clr(ph_clr), .run(ph_run),
    .tick(us_tick), .limit(ph_limit), .done(ph_done)
  );

  // Erase progress; frozen while suspended.
  assign prog_run = (state == ST_RUN) || (state == ST_SPEND);
  assign prog_clr = start_evt || (state == ST_IDLE);

  ebs_tick_ctr #(.W(CNT_W)) u_prog (
    .clk(clk), .rst(rst), .clr(prog_clr), .run(prog_run),
    .tick(us_tick), .limit(target_q), .done(prog_done)
  );

  ebs_block_set #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .NB_W(NB_W)) u_set (
    .clk(clk), .rst(rst), .add_en(sel_acc), .add_idx(sel_idx),
    .prune_en(start_evt), .prot(blk_prot), .clear_en(clear_set),
    .query_idx(query_idx), .mask(erase_mask), .live_cnt(live_cnt), .q_hit(q_hit)
  );

  assign busy          = (state != ST_IDLE);
  assign started       = started_q;
  assign suspended     = (state == ST_SUSP);
  assign query_erasing = q_hit && busy;
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk #(
  parameter int NUM_BLK = 8,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               sel_valid,
  input logic [IDX_W-1:0]   sel_idx,
  input logic               abort_req,
  input logic [NUM_BLK-1:0] erase_mask,
  input logic               busy,
  input logic               started,
  input logic               suspended
);
  logic [IDX_W-1:0] last_idx;
  always_ff @(posedge clk) last_idx <= sel_idx;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !started && !suspended && erase_mask == '0));

  a_r2_select_sets_bit: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !busy) |=> erase_mask[last_idx]);

  a_r3_started_busy: assert property (@(posedge clk) disable iff (rst)
    started |-> busy);

  a_r4_mask_frozen: assert property (@(posedge clk) disable iff (rst)
    (started && busy) |=> (!busy || erase_mask == $past(erase_mask)));

  a_r7_suspend_busy: assert property (@(posedge clk) disable iff (rst)
    suspended |-> busy);

  a_r10_abort_unsuspends: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !suspended);
endmodule

bind erase_sched erase_sched_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_idx(sel_idx),
  .abort_req(abort_req), .erase_mask(erase_mask), .busy(busy),
  .started(started), .suspended(suspended)
);

// File: tb/erase_sched_test.sv
module erase_sched_test;
  localparam int NB = 8;
  localparam logic [2:0] OP_NOP = 3'd0, OP_SEL = 3'd1, OP_SUS = 3'd2,
                         OP_RES = 3'd3, OP_ABT = 3'd4;

  // {op, idx, wait, busy, started, suspended, mask, query_idx}
  localparam logic [27:0] TBL [26] = '{
    {OP_SEL, 3'd2, 8'd0,   1'b1, 1'b0, 1'b0, 8'h04, 3'd2},
    {OP_NOP, 3'd0, 8'd47,  1'b1, 1'b0, 1'b0, 8'h04, 3'd2},
    {OP_SEL, 3'd5, 8'd0,   1'b1, 1'b0, 1'b0, 8'h24, 3'd5},
    {OP_NOP, 3'd0, 8'd48,  1'b1, 1'b0, 1'b0, 8'h24, 3'd0},
    {OP_NOP, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h24, 3'd5},
    {OP_SEL, 3'd6, 8'd0,   1'b1, 1'b1, 1'b0, 8'h24, 3'd6},
    {OP_SUS, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h24, 3'd2},
    {OP_NOP, 3'd0, 8'd13,  1'b1, 1'b1, 1'b0, 8'h24, 3'd0},
    {OP_NOP, 3'd0, 8'd0,   1'b1, 1'b1, 1'b1, 8'h24, 3'd5},
    {OP_NOP, 3'd0, 8'd30,  1'b1, 1'b1, 1'b1, 8'h24, 3'd2},
    {OP_RES, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h24, 3'd2},
    {OP_NOP, 3'd0, 8'd21,  1'b1, 1'b1, 1'b0, 8'h24, 3'd5},
    {OP_NOP, 3'd0, 8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 3'd2},
    {OP_SEL, 3'd4, 8'd0,   1'b1, 1'b0, 1'b0, 8'h10, 3'd4},
    {OP_NOP, 3'd0, 8'd49,  1'b1, 1'b1, 1'b0, 8'h00, 3'd4},
    {OP_NOP, 3'd0, 8'd98,  1'b1, 1'b1, 1'b0, 8'h00, 3'd0},
    {OP_NOP, 3'd0, 8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 3'd0},
    {OP_SEL, 3'd1, 8'd0,   1'b1, 1'b0, 1'b0, 8'h02, 3'd1},
    {OP_SUS, 3'd0, 8'd0,   1'b1, 1'b0, 1'b1, 8'h02, 3'd1},
    {OP_SEL, 3'd3, 8'd0,   1'b1, 1'b0, 1'b1, 8'h02, 3'd3},
    {OP_NOP, 3'd0, 8'd100, 1'b1, 1'b0, 1'b1, 8'h02, 3'd1},
    {OP_RES, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h02, 3'd1},
    {OP_SEL, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h02, 3'd0},
    {OP_ABT, 3'd0, 8'd0,   1'b1, 1'b1, 1'b0, 8'h02, 3'd1},
    {OP_NOP, 3'd0, 8'd8,   1'b1, 1'b1, 1'b0, 8'h02, 3'd1},
    {OP_NOP, 3'd0, 8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 3'd1}
  };

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b1;
  logic sel_valid = 1'b0, susp_req = 1'b0, resume_req = 1'b0, abort_req = 1'b0;
  logic [2:0] sel_idx = '0, query_idx = '0;
  logic [NB-1:0] blk_prot = 8'h10;
  logic [NB-1:0] erase_mask;
  logic busy, started, suspended, query_erasing;
  int checks = 0, errors = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  erase_sched uut (
    .clk(clk), .rst(rst), .us_tick(tick_en), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .susp_req(susp_req), .resume_req(resume_req), .abort_req(abort_req),
    .blk_prot(blk_prot), .query_idx(query_idx), .erase_mask(erase_mask),
    .busy(busy), .started(started), .suspended(suspended), .query_erasing(query_erasing)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [2:0] idx);
    sel_idx    = idx;
    sel_valid  = (op == OP_SEL);
    susp_req   = (op == OP_SUS);
    resume_req = (op == OP_RES);
    abort_req  = (op == OP_ABT);
    @(negedge clk);
    sel_valid = 1'b0; susp_req = 1'b0; resume_req = 1'b0; abort_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string row_tag(int i);
    if (i < 13)      return "R3 R4 R5 R7 R9";
    else if (i < 17) return "R6";
    else             return "R8 R10";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: state held in reset
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 mask", erase_mask, 8'h00);
    rst = 1'b0;
    idle(1);
    chk("R1 started", {6'd0, started, suspended}, 8'd0);

    for (int i = 0; i < 26; i++) begin
      logic [27:0] r;
      r = TBL[i];
      query_idx = r[2:0];
      apply(r[27:25], r[24:22]);
      idle(int'(r[21:14]));
      chk({row_tag(i), " R5 busy"}, {7'd0, busy}, {7'd0, r[13]});
      chk({row_tag(i), " R3 started"}, {7'd0, started}, {7'd0, r[12]});
      chk({row_tag(i), " suspended"}, {7'd0, suspended}, {7'd0, r[11]});
      chk({row_tag(i), " R2 mask"}, erase_mask, r[10:3]);
      chk("R11 query", {7'd0, query_erasing}, {7'd0, r[10:3] >> r[2:0]} & 8'd1 & {7'd0, r[13]});
    end

    blk_prot = 8'h00;
    // R9: two running-phase suspends, 40-tick erase of blocks 0 and 1
    apply(OP_SEL, 3'd0); apply(OP_SEL, 3'd1);
    idle(49); chk("R3 not yet", {7'd0, started}, 8'd0);
    idle(1);  chk("R3 start", {7'd0, started}, 8'd1);
    apply(OP_SUS, 3'd0); idle(15); chk("R9 susp1", {7'd0, suspended}, 8'd1);
    apply(OP_RES, 3'd0); apply(OP_SUS, 3'd0); idle(15);
    chk("R9 susp2", {7'd0, suspended}, 8'd1);
    apply(OP_RES, 3'd0); idle(7); chk("R9 still busy", {7'd0, busy}, 8'd1);
    idle(1); chk("R9 done", {7'd0, busy}, 8'd0);

    // R7: erase ends inside the suspend latency
    apply(OP_SEL, 3'd0); idle(50); idle(16);
    apply(OP_SUS, 3'd0); idle(2); chk("R7 pending", {7'd0, busy}, 8'd1);
    idle(1);
    chk("R7 ends first busy", {7'd0, busy}, 8'd0);
    chk("R7 ends first susp", {7'd0, suspended}, 8'd0);

    // R3/R10: no ticks freezes window; abort from window
    tick_en = 1'b0;
    apply(OP_SEL, 3'd3); idle(200);
    chk("R3 tick gated", {7'd0, started}, 8'd0);
    chk("R2 mask blk3", erase_mask, 8'h08);
    apply(OP_ABT, 3'd0); idle(20);
    chk("R10 abort waits", {7'd0, busy}, 8'd1);
    tick_en = 1'b1; idle(9);
    chk("R10 abort latency", {7'd0, busy}, 8'd1);
    idle(1);
    chk("R10 abort done", {7'd0, busy}, 8'd0);
    chk("R10 mask cleared", erase_mask, 8'h00);

    // R1: reset during an operation
    apply(OP_SEL, 3'd2); idle(5);
    rst = 1'b1; idle(1);
    chk("R1 mid reset busy", {7'd0, busy}, 8'd0);
    chk("R1 mid reset mask", erase_mask, 8'h00);
    rst = 1'b0; idle(1);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule